// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Data-Cache Lookup

This block is the lookup stage of a write-back data cache. It picks the set only from address bits below the page boundary, so those bits need no translation. In the same cycle, an eight-entry fully associative translation buffer turns the virtual page number into a physical page number. That physical page number is then compared with the stored tag of every way in the chosen set. The default geometry is 16 KB, four ways, 32-byte lines and 4 KB pages. The set index and line offset together exactly fill the page offset. Because of this, two virtual pages mapped to one physical page always reach the same line, and no address-space identifier is stored.

The processor side issues one request at a time. The outcome is reported one cycle after acceptance as a hit (with read data), a cache miss or a translation miss. A cache miss starts a refill: a dirty victim is written back first, then the whole line is fetched on a single-beat port. The processor then repeats the request. Translations are loaded by an external walker through a fill port. A flush command names a virtual address and removes just the line holding it, writing it back first if it is dirty.

Top module: `vipt_cache_lookup`

## Requirements
- R1: After reset no line and no translation entry is valid, req_ready and flush_ready are high, and all response outputs are low.
- R2: A request whose page has no translation gives resp_tlb_miss one cycle after acceptance, starts no write-back or line read, and changes no line.
- R3: The translation buffer holds 8 entries. A fill whose virtual page is already present overwrites that entry. Any other fill takes the next slot in round-robin order, starting at slot 0, so the ninth distinct page displaces the first.
- R4: Set index is vaddr[11:5] and word select is vaddr[4:2]. A read hit returns that 32-bit word on resp_rdata, with resp_hit high, one cycle after acceptance. Word k of a line occupies line bits [32k+31:32k].
- R5: A hit is decided only by comparing the translated physical page number with valid stored tags. Two virtual pages translated to one physical page hit the same line with no memory traffic.
- R6: A read miss gives resp_miss one cycle after acceptance. It then requests the line at {ppn, index, 5'b0} and keeps mem_rd_valid and mem_rd_addr steady until mem_fill_valid. req_ready stays low until the line is installed clean.
- R7: A write hit replaces the selected word and marks the line dirty. A write miss is reported as a miss and allocates the line, so the repeated write hits.
- R8: The victim way of each set advances round-robin 0,1,2,3,0 on every refill. A valid dirty victim is written back at its own physical line address, with its full line, before the new line is requested. A clean victim is not written back.
- R9: A flush of a present dirty line writes it back and then invalidates it. A flush of a present clean line invalidates it with no write-back. A flush of an absent line changes nothing.
- R10: When a flush and a request address the same set in one cycle, the flush is taken first: req_ready is low that cycle and the request is accepted on the next. A flush of a clean line in another set does not stall the request.
- R11: A flush whose page has no translation changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_vaddr | input | 32 | Request virtual byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write word |
| resp_hit | output | 1 | Request hit (one cycle after acceptance) |
| resp_miss | output | 1 | Request missed the cache |
| resp_tlb_miss | output | 1 | Request had no translation |
| resp_rdata | output | 32 | Read word on a read hit |
| tlb_fill_valid | input | 1 | Write one translation entry |
| tlb_fill_vpn | input | 20 | Virtual page number to load |
| tlb_fill_ppn | input | 20 | Physical page number to load |
| flush_valid | input | 1 | Flush command present |
| flush_ready | output | 1 | Flush accepted this cycle if valid |
| flush_vaddr | input | 32 | Virtual address of line to flush |
| mem_wb_valid | output | 1 | Line write-back request |
| mem_wb_ack | input | 1 | Write-back taken |
| mem_wb_addr | output | 32 | Physical line address of write-back |
| mem_wb_data | output | 256 | Line being written back |
| mem_rd_valid | output | 1 | Line read request |
| mem_rd_addr | output | 32 | Physical line address to fetch |
| mem_fill_valid | input | 1 | Refill line present |
| mem_fill_data | input | 256 | Refill line |

## Verification
A flush and a processor lookup can land in the same cycle, and the bench drives both on one clock edge in two arrangements. In the first, both address the same set: req_ready must read low just after the inputs are driven, the next cycle must show no response, and the cycle after must report a miss because the line was flushed first. In the second, the flush targets a clean line in a different set: the request must be accepted at once and return the expected data, and a later read of the flushed address must miss.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  // Controller sequencing: idle lookup, victim write-back, line read,
  // flush write-back.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_RD   = 2'd2,
    ST_FLWB = 2'd3
  } op_state_e;

endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ENTRIES = 8,
  parameter int PORTS   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fill_en,
  input  logic [VPN_W-1:0]            fill_vpn,
  input  logic [PPN_W-1:0]            fill_ppn,
  input  logic [PORTS-1:0][VPN_W-1:0] lk_vpn,
  output logic [PORTS-1:0]            lk_hit,
  output logic [PORTS-1:0][PPN_W-1:0] lk_ppn
);
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            vld_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [SLOT_W-1:0]             ptr_q, ptr_d;
  logic [ENTRIES-1:0]            fmatch;
  logic                          fmatch_any;
  logic [SLOT_W-1:0]             fmatch_slot, slot;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_fmatch
    assign fmatch[e] = vld_q[e] && (vpn_q[e] == fill_vpn);
  end

  always_comb begin
    fmatch_slot = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (fmatch[e]) fmatch_slot = SLOT_W'(e);
  end

  assign fmatch_any = |fmatch;
  assign slot       = fmatch_any ? fmatch_slot : ptr_q;

  always_comb begin
    ptr_d = ptr_q;
    if (fill_en && !fmatch_any)
      ptr_d = (ptr_q == SLOT_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      if (fill_en) vld_q[slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      vpn_q[slot] <= fill_vpn;
      ppn_q[slot] <= fill_ppn;
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [ENTRIES-1:0] hv;
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign hv[e] = vld_q[e] && (vpn_q[e] == lk_vpn[p]);
    end
    always_comb begin
      lk_ppn[p] = '0;
      for (int e = 0; e < ENTRIES; e++)
        if (hv[e]) lk_ppn[p] = lk_ppn[p] | ppn_q[e];
    end
    assign lk_hit[p] = |hv;

    // R3: a page never sits in two entries, since fills overwrite a match
    tlb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hv));
  end

endmodule

// File: rtl/vipt_way_match.sv
module vipt_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  parameter int WAY_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           ptag,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  logic [WAYS-1:0] hv;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hv[w] = vld[w] && (tags[w] == ptag);
  end

  always_comb begin
    way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hv[w]) way = WAY_W'(w);
  end

  assign hit = |hv;

  // R5: the refill logic never installs a physical line twice in one set
  way_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hv));

endmodule

// File: rtl/vipt_cache_lookup.sv
module vipt_cache_lookup #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter int OFF_W  = 5,
  parameter int WAYS   = 4,
  parameter int TLB_N  = 8,
  parameter int WORD_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_vaddr,
  input  logic                       req_we,
  input  logic [WORD_W-1:0]          req_wdata,
  output logic                       resp_hit,
  output logic                       resp_miss,
  output logic                       resp_tlb_miss,
  output logic [WORD_W-1:0]          resp_rdata,
  input  logic                       tlb_fill_valid,
  input  logic [ADDR_W-PAGE_W-1:0]   tlb_fill_vpn,
  input  logic [ADDR_W-PAGE_W-1:0]   tlb_fill_ppn,
  input  logic                       flush_valid,
  output logic                       flush_ready,
  input  logic [ADDR_W-1:0]          flush_vaddr,
  output logic                       mem_wb_valid,
  input  logic                       mem_wb_ack,
  output logic [ADDR_W-1:0]          mem_wb_addr,
  output logic [(8<<OFF_W)-1:0]      mem_wb_data,
  output logic                       mem_rd_valid,
  output logic [ADDR_W-1:0]          mem_rd_addr,
  input  logic                       mem_fill_valid,
  input  logic [(8<<OFF_W)-1:0]      mem_fill_data
);
  import vipt_pkg::*;

  // Index plus offset equals the page offset, so ways x page = capacity.
  localparam int IDX_W  = PAGE_W - OFF_W;
  localparam int SETS   = 1 << IDX_W;
  localparam int PN_W   = ADDR_W - PAGE_W;
  localparam int LINE_W = 8 << OFF_W;
  localparam int BSEL_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_W - BSEL_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0][PN_W-1:0]   tag_q  [SETS];
  logic [WAYS-1:0][LINE_W-1:0] data_q [SETS];
  logic [WAYS-1:0]             vld_q  [SETS];
  logic [WAYS-1:0]             dty_q  [SETS];
  logic [WAY_W-1:0]            rr_q   [SETS];

  op_state_e          state_q, state_d;
  logic [IDX_W-1:0]   op_idx_q, op_idx_d;
  logic [WAY_W-1:0]   op_way_q, op_way_d;
  logic [PN_W-1:0]    op_tag_q;
  logic               ld_ctx;

  // address fields
  logic [IDX_W-1:0]   r_idx, f_idx;
  logic [WSEL_W-1:0]  r_word;
  logic [1:0][PN_W-1:0] lk_vpn, lk_ppn;
  logic [1:0]         lk_hit;
  logic               r_way_hit, f_way_hit;
  logic [WAY_W-1:0]   r_way, f_way, vic_way;
  logic               unused_bits;

  assign r_idx  = req_vaddr[PAGE_W-1:OFF_W];
  assign f_idx  = flush_vaddr[PAGE_W-1:OFF_W];
  assign r_word = req_vaddr[OFF_W-1:BSEL_W];
  assign lk_vpn[0] = req_vaddr[ADDR_W-1:PAGE_W];
  assign lk_vpn[1] = flush_vaddr[ADDR_W-1:PAGE_W];
  assign unused_bits = ^{req_vaddr[BSEL_W-1:0], flush_vaddr[OFF_W-1:0]};

  vipt_tlb #(.VPN_W(PN_W), .PPN_W(PN_W), .ENTRIES(TLB_N), .PORTS(2)) u_tlb (
    .clk, .rst_n,
    .fill_en(tlb_fill_valid), .fill_vpn(tlb_fill_vpn), .fill_ppn(tlb_fill_ppn),
    .lk_vpn, .lk_hit, .lk_ppn
  );

  vipt_way_match #(.WAYS(WAYS), .TAG_W(PN_W), .WAY_W(WAY_W)) u_req_match (
    .clk, .rst_n, .vld(vld_q[r_idx]), .tags(tag_q[r_idx]), .ptag(lk_ppn[0]),
    .hit(r_way_hit), .way(r_way)
  );

  vipt_way_match #(.WAYS(WAYS), .TAG_W(PN_W), .WAY_W(WAY_W)) u_fl_match (
    .clk, .rst_n, .vld(vld_q[f_idx]), .tags(tag_q[f_idx]), .ptag(lk_ppn[1]),
    .hit(f_way_hit), .way(f_way)
  );

  // arbitration between flush and lookup
  logic idle, same_set, fl_hit, fl_dirty, fl_clean;
  logic rq_go, rq_hit, rq_miss, rq_tmiss, wr_hit, vic_dirty;
  logic install, fl_inv_done;

  assign idle        = (state_q == ST_IDLE);
  assign flush_ready = idle;
  assign same_set    = (f_idx == r_idx);
  assign fl_hit      = flush_valid && idle && lk_hit[1] && f_way_hit;
  assign fl_dirty    = fl_hit && dty_q[f_idx][f_way];
  assign fl_clean    = fl_hit && !dty_q[f_idx][f_way];
  assign req_ready   = idle && !(flush_valid && (same_set || fl_dirty));
  assign rq_go       = req_valid && req_ready;
  assign rq_hit      = rq_go && lk_hit[0] && r_way_hit;
  assign rq_miss     = rq_go && lk_hit[0] && !r_way_hit;
  assign rq_tmiss    = rq_go && !lk_hit[0];
  assign wr_hit      = rq_hit && req_we;
  assign vic_way     = rr_q[r_idx];
  assign vic_dirty   = vld_q[r_idx][vic_way] && dty_q[r_idx][vic_way];
  assign install     = (state_q == ST_RD) && mem_fill_valid;
  assign fl_inv_done = (state_q == ST_FLWB) && mem_wb_ack;

  always_comb begin
    state_d  = state_q;
    ld_ctx   = fl_dirty || rq_miss;
    op_idx_d = fl_dirty ? f_idx : r_idx;
    op_way_d = fl_dirty ? f_way : vic_way;
    case (state_q)
      ST_IDLE: if (fl_dirty)     state_d = ST_FLWB;
               else if (rq_miss) state_d = vic_dirty ? ST_WB : ST_RD;
      ST_WB:   if (mem_wb_ack)   state_d = ST_RD;
      ST_RD:   if (mem_fill_valid) state_d = ST_IDLE;
      ST_FLWB: if (mem_wb_ack)   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_idx_q <= '0;
      op_way_q <= '0;
      op_tag_q <= '0;
    end else begin
      state_q <= state_d;
      if (ld_ctx) begin
        op_idx_q <= op_idx_d;
        op_way_q <= op_way_d;
        op_tag_q <= lk_ppn[0];
      end
    end
  end

  // line state: valid, dirty, round-robin pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        dty_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else begin
      if (install) begin
        vld_q[op_idx_q][op_way_q] <= 1'b1;
        dty_q[op_idx_q][op_way_q] <= 1'b0;
        rr_q[op_idx_q]            <= rr_q[op_idx_q] + 1'b1;
      end
      if (wr_hit)   dty_q[r_idx][r_way] <= 1'b1;
      if (fl_clean) vld_q[f_idx][f_way] <= 1'b0;
      if (fl_inv_done) begin
        vld_q[op_idx_q][op_way_q] <= 1'b0;
        dty_q[op_idx_q][op_way_q] <= 1'b0;
      end
    end
  end

  // tag and data arrays carry no reset
  always_ff @(posedge clk) begin
    if (install) begin
      data_q[op_idx_q][op_way_q] <= mem_fill_data;
      tag_q[op_idx_q][op_way_q]  <= op_tag_q;
    end
    if (wr_hit) data_q[r_idx][r_way][r_word*WORD_W +: WORD_W] <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_hit      <= 1'b0;
      resp_miss     <= 1'b0;
      resp_tlb_miss <= 1'b0;
      resp_rdata    <= '0;
    end else begin
      resp_hit      <= rq_hit;
      resp_miss     <= rq_miss;
      resp_tlb_miss <= rq_tmiss;
      if (rq_hit && !req_we)
        resp_rdata <= data_q[r_idx][r_way][r_word*WORD_W +: WORD_W];
    end
  end

  assign mem_wb_valid = (state_q == ST_WB) || (state_q == ST_FLWB);
  assign mem_wb_addr  = {tag_q[op_idx_q][op_way_q], op_idx_q, {OFF_W{1'b0}}};
  assign mem_wb_data  = data_q[op_idx_q][op_way_q];
  assign mem_rd_valid = (state_q == ST_RD);
  assign mem_rd_addr  = {op_tag_q, op_idx_q, {OFF_W{1'b0}}};

  // R2
  tlbmiss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_tmiss |=> !mem_rd_valid && !mem_wb_valid);

  // R4
  resp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> $past(req_valid && req_ready));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_fill_valid |=> mem_rd_valid && $stable(mem_rd_addr));

  // R9
  wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wb_valid && mem_wb_ack |=> !mem_wb_valid);

  // R10
  flush_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid && flush_ready && req_valid && same_set
      |=> !resp_hit && !resp_miss && !resp_tlb_miss);

endmodule

// File: tb/test_vipt_cache_lookup.sv
module test_vipt_cache_lookup;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid, req_ready, req_we;
  logic [31:0]  req_vaddr, req_wdata;
  logic         resp_hit, resp_miss, resp_tlb_miss;
  logic [31:0]  resp_rdata;
  logic         tlb_fill_valid;
  logic [19:0]  tlb_fill_vpn, tlb_fill_ppn;
  logic         flush_valid, flush_ready;
  logic [31:0]  flush_vaddr;
  logic         mem_wb_valid, mem_wb_ack;
  logic [31:0]  mem_wb_addr;
  logic [255:0] mem_wb_data;
  logic         mem_rd_valid;
  logic [31:0]  mem_rd_addr;
  logic         mem_fill_valid;
  logic [255:0] mem_fill_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  vipt_cache_lookup i_vipt_cache_lookup (
    .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .req_we, .req_wdata,
    .resp_hit, .resp_miss, .resp_tlb_miss, .resp_rdata,
    .tlb_fill_valid, .tlb_fill_vpn, .tlb_fill_ppn,
    .flush_valid, .flush_ready, .flush_vaddr,
    .mem_wb_valid, .mem_wb_ack, .mem_wb_addr, .mem_wb_data,
    .mem_rd_valid, .mem_rd_addr, .mem_fill_valid, .mem_fill_data
  );

  int n_chk = 0, n_err = 0;
  int wb_cnt = 0, rd_cnt = 0, ev = 0, wb_ev = 0, rd_ev = 0;
  logic [31:0]  wb_addr_seen = '0, rd_addr_seen = '0;
  logic [255:0] wb_data_seen = '0;

  function automatic logic [31:0] mword(input logic [31:0] pa);
    return {pa[31:2], 2'b00} ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [255:0] mline(input logic [31:0] la);
    logic [255:0] l;
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = mword({la[31:5], 5'b0} + 32'(i*4));
    return l;
  endfunction

  task automatic chk(input string rq, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // memory responder
  initial begin
    mem_wb_ack = 1'b0;
    mem_fill_valid = 1'b0;
    mem_fill_data = '0;
    forever begin
      @(negedge clk);
      if (mem_wb_valid && !mem_wb_ack) begin
        wb_cnt++; ev++; wb_ev = ev;
        wb_addr_seen = mem_wb_addr;
        wb_data_seen = mem_wb_data;
        mem_wb_ack = 1'b1;
      end else mem_wb_ack = 1'b0;
      if (mem_rd_valid && !mem_fill_valid) begin
        rd_cnt++; ev++; rd_ev = ev;
        rd_addr_seen = mem_rd_addr;
        mem_fill_data = mline(mem_rd_addr);
        mem_fill_valid = 1'b1;
      end else mem_fill_valid = 1'b0;
    end
  end

  task automatic wait_idle();
    while (!flush_ready) @(negedge clk);
  endtask

  task automatic access(input logic [31:0] va, input logic we, input logic [31:0] wd,
                        output logic h, output logic m, output logic t, output logic [31:0] rd);
    wait_idle();
    req_vaddr = va; req_we = we; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    h = resp_hit; m = resp_miss; t = resp_tlb_miss; rd = resp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic load(input logic [31:0] va, output logic [31:0] rd);
    logic h, m, t;
    access(va, 1'b0, 32'h0, h, m, t, rd);
    if (m) access(va, 1'b0, 32'h0, h, m, t, rd);
  endtask

  task automatic tlb_fill(input logic [19:0] vpn, input logic [19:0] ppn);
    tlb_fill_vpn = vpn; tlb_fill_ppn = ppn; tlb_fill_valid = 1'b1;
    @(negedge clk);
    tlb_fill_valid = 1'b0;
  endtask

  task automatic do_flush(input logic [31:0] va);
    wait_idle();
    flush_vaddr = va; flush_valid = 1'b1;
    @(negedge clk);
    flush_valid = 1'b0;
    wait_idle();
  endtask

  logic h, m, t;
  logic [31:0] rd;
  int w0, r0;

  task automatic t_reset();
    chk("R1 req_ready", req_ready, 1);
    chk("R1 flush_ready", flush_ready, 1);
    chk("R1 resp quiet", {resp_hit, resp_miss, resp_tlb_miss}, 0);
    access(32'h0001_0040, 1'b0, 0, h, m, t, rd);
    chk("R1 R2 no translation", {h, m, t}, 3'b001);
    chk("R2 no memory read", rd_cnt, 0);
    chk("R2 ready kept", req_ready, 1);
  endtask

  task automatic t_first_miss();
    tlb_fill(20'h00010, 20'h00080);
    access(32'h0001_0048, 1'b0, 0, h, m, t, rd);
    chk("R1 R6 cold miss", {h, m, t}, 3'b010);
    chk("R6 ready low during refill", req_ready, 0);
    wait_idle();
    chk("R6 refill address", rd_addr_seen, 32'h0008_0040);
    access(32'h0001_0048, 1'b0, 0, h, m, t, rd);
    chk("R4 hit after refill", h, 1);
    chk("R4 read word", rd, mword(32'h0008_0048));
  endtask

  task automatic t_alias();
    tlb_fill(20'h00020, 20'h00080);
    r0 = rd_cnt;
    access(32'h0002_004C, 1'b0, 0, h, m, t, rd);
    chk("R5 alias hit", h, 1);
    chk("R5 alias data", rd, mword(32'h0008_004C));
    chk("R5 no refill", rd_cnt, r0);
  endtask

  task automatic t_write_hit();
    access(32'h0001_0044, 1'b1, 32'hDEAD_BEEF, h, m, t, rd);
    chk("R7 write hit", h, 1);
    access(32'h0002_0044, 1'b0, 0, h, m, t, rd);
    chk("R7 written word via alias", rd, 32'hDEAD_BEEF);
  endtask

  task automatic t_write_alloc();
    tlb_fill(20'h00030, 20'h00090);
    access(32'h0003_0060, 1'b1, 32'h1234_5678, h, m, t, rd);
    chk("R7 write miss", {h, m}, 2'b01);
    wait_idle();
    chk("R7 allocate address", rd_addr_seen, 32'h0009_0060);
    access(32'h0003_0060, 1'b1, 32'h1234_5678, h, m, t, rd);
    chk("R7 repeated write hits", h, 1);
    load(32'h0003_0060, rd);
    chk("R7 written word", rd, 32'h1234_5678);
    load(32'h0003_0064, rd);
    chk("R7 neighbour word", rd, mword(32'h0009_0064));
  endtask

  task automatic t_rr_evict();
    tlb_fill(20'h00041, 20'h000A1);
    tlb_fill(20'h00042, 20'h000A2);
    tlb_fill(20'h00043, 20'h000A3);
    load(32'h0004_1040, rd);
    load(32'h0004_2040, rd);
    load(32'h0004_3040, rd);
    chk("R8 invalid victims need no write-back", wb_cnt, 0);
    tlb_fill(20'h00044, 20'h000A4);
    w0 = wb_cnt;
    access(32'h0004_4040, 1'b0, 0, h, m, t, rd);
    chk("R8 fifth line misses", m, 1);
    wait_idle();
    chk("R8 dirty victim written", wb_cnt, w0 + 1);
    chk("R8 victim address", wb_addr_seen, 32'h0008_0040);
    chk("R8 victim data", wb_data_seen[63:32], 32'hDEAD_BEEF);
    chk("R8 write-back before read", wb_ev < rd_ev, 1);
    chk("R8 new line address", rd_addr_seen, 32'h000A_4040);
    access(32'h0004_4040, 1'b0, 0, h, m, t, rd);
    chk("R8 new line hits", h, 1);
    w0 = wb_cnt;
    access(32'h0001_0040, 1'b0, 0, h, m, t, rd);
    chk("R8 evicted line misses", m, 1);
    wait_idle();
    chk("R8 clean victim not written", wb_cnt, w0);
  endtask

  task automatic t_tlb();
    tlb_fill(20'h00050, 20'h000B0);
    tlb_fill(20'h00060, 20'h000C0);
    r0 = rd_cnt;
    access(32'h0001_0040, 1'b0, 0, h, m, t, rd);
    chk("R3 ninth page displaces first", t, 1);
    chk("R3 R2 no read on translation miss", rd_cnt, r0);
    tlb_fill(20'h00020, 20'h00090);
    access(32'h0002_0060, 1'b0, 0, h, m, t, rd);
    chk("R3 overwritten entry hit", h, 1);
    chk("R3 overwritten entry data", rd, 32'h1234_5678);
    access(32'h0003_0060, 1'b0, 0, h, m, t, rd);
    chk("R3 other entry kept", {h, rd}, {1'b1, 32'h1234_5678});
  endtask

  task automatic t_flush();
    w0 = wb_cnt;
    do_flush(32'h0003_0060);
    chk("R9 dirty flush writes back", wb_cnt, w0 + 1);
    chk("R9 flush address", wb_addr_seen, 32'h0009_0060);
    chk("R9 flush data", wb_data_seen[31:0], 32'h1234_5678);
    access(32'h0003_0060, 1'b0, 0, h, m, t, rd);
    chk("R9 dirty line invalidated", m, 1);
    wait_idle();
    w0 = wb_cnt;
    do_flush(32'h0003_0060);
    chk("R9 clean flush no write-back", wb_cnt, w0);
    access(32'h0003_0060, 1'b0, 0, h, m, t, rd);
    chk("R9 clean line invalidated", m, 1);
    wait_idle();
    w0 = wb_cnt;
    do_flush(32'h0003_00E0);
    chk("R9 absent flush no write-back", wb_cnt, w0);
    access(32'h0003_0060, 1'b0, 0, h, m, t, rd);
    chk("R9 absent flush leaves lines", h, 1);
  endtask

  task automatic t_flush_tlbmiss();
    w0 = wb_cnt;
    do_flush(32'h0777_7060);
    chk("R11 untranslated flush no write-back", wb_cnt, w0);
    access(32'h0003_0060, 1'b0, 0, h, m, t, rd);
    chk("R11 line still present", h, 1);
  endtask

  task automatic t_concurrent();
    wait_idle();
    flush_vaddr = 32'h0003_0060; flush_valid = 1'b1;
    req_vaddr = 32'h0003_0060; req_we = 1'b0; req_valid = 1'b1;
    #1;
    chk("R10 same set stalls request", req_ready, 0);
    @(negedge clk);
    chk("R10 no response while stalled", {resp_hit, resp_miss, resp_tlb_miss}, 0);
    flush_valid = 1'b0;
    @(negedge clk);
    chk("R10 request sees flushed line", resp_miss, 1);
    req_valid = 1'b0;
    wait_idle();
    flush_vaddr = 32'h0003_0060; flush_valid = 1'b1;
    req_vaddr = 32'h0004_2040; req_we = 1'b0; req_valid = 1'b1;
    #1;
    chk("R10 other set not stalled", req_ready, 1);
    @(negedge clk);
    chk("R10 other set hit", {resp_hit, resp_rdata}, {1'b1, mword(32'h000A_2040)});
    flush_valid = 1'b0; req_valid = 1'b0;
    access(32'h0003_0060, 1'b0, 0, h, m, t, rd);
    chk("R10 concurrent flush applied", m, 1);
    wait_idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    req_valid = 0; req_vaddr = '0; req_we = 0; req_wdata = '0;
    tlb_fill_valid = 0; tlb_fill_vpn = '0; tlb_fill_ppn = '0;
    flush_valid = 0; flush_vaddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_miss();
    t_alias();
    t_write_hit();
    t_write_alloc();
    t_rr_evict();
    t_tlb();
    t_flush();
    t_flush_tlbmiss();
    t_concurrent();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule